// File: doc/BRIEF.md
# Exchange-Status Reference Address Selector

This block decides how a status-exchange instruction forms its reference address. It takes the 32-bit instruction word together with the context the instruction runs in: an ordinary program step, an interrupt entry or a trap entry. It also takes the two processor mode bits that together define extended addressing, and the mapping bit of the current status words. From these it selects either a 20-bit or a 17-bit address field. It reports whether index arithmetic may be applied, and whether the address is real or goes through the memory map. It always reports that indirection is permitted.

When the instruction's indirect flag is set, a small sequencer issues one read through a request/acknowledge memory port. It then replaces the address with the fetched word, cut to the same width and under the same real/mapped treatment as the direct address. The result is presented on registered outputs with a one-cycle done pulse. Index arithmetic, address translation and the status-word load itself belong to neighbouring logic.

Top module: `xstat_addr_sel`

## Requirements
- R1: Instruction bits are numbered from the most significant end (bit 0 = `instr[31]`). Bit 0 is the indirect flag and bit 10 (`instr[21]`) is the address-type flag AT. The long field is bits 12–31 (`instr[19:0]`) and the short field is bits 15–31 (`instr[16:0]`).
- R2: In ordinary program context (`ctx`=2'b00) with AT=0, the address is the long field, `idx_ok`=0, `mapped`=0 and `short_sel`=0.
- R3: In ordinary program context with AT=1, the address is the short field zero-extended to 20 bits, with `short_sel`=1, `idx_ok`=1 and `mapped` equal to `stat_map`.
- R4: In interrupt (`ctx`=2'b01) or trap (2'b10 or 2'b11) context with extended addressing (`mode_ma`=1 and `mode_mm`=0), the results are those of R2/R3 for the same AT.
- R5: In interrupt or trap context without extended addressing, the address is always the long field with `short_sel`=0. AT=0 gives `idx_ok`=0 and `mapped`=0. AT=1 gives `idx_ok`=1 and `mapped`=`stat_map`.
- R6: `ind_ok` is 1 at all times after reset.
- R7: With the indirect flag set, `mem_req` rises the cycle after the request and holds its address (the direct address of R2–R5) stable until `mem_ack`. The final address is `mem_rdata` cut to the selected width, and the flags are unchanged from the direct case.
- R8: `done` is high for exactly one cycle per request. For a direct request this is the cycle after the request; for an indirect request it is the cycle after `mem_ack`.
- R9: A request presented while a fetch is outstanding is ignored. It changes neither the pending fetch nor its result.
- R10: After reset `done`, `mem_req`, `addr_out`, `idx_ok`, `mapped` and `short_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start one address selection |
| instr | input | 32 | Instruction word |
| ctx | input | 2 | 00 program, 01 interrupt, 10/11 trap |
| mode_ma | input | 1 | Mode bit; with `mode_mm`=0 enables extended addressing |
| mode_mm | input | 1 | Mode bit |
| stat_map | input | 1 | Mapping bit of the current status words |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 20 | Indirect read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| addr_out | output | 20 | Selected reference address |
| short_sel | output | 1 | 1 when the 17-bit field was used |
| idx_ok | output | 1 | Indexing allowed |
| ind_ok | output | 1 | Indirection allowed |
| mapped | output | 1 | 1 = mapped, 0 = real |

## Verification
Several properties are checked on every cycle. A held read request keeps a stable address. An acknowledge is followed by `done`. No `done` appears while a fetch is waiting. A short result never has its upper three bits set. A direct AT=0 request always produces an unindexed real result. The full decision table across context, mode bits, AT and the mapping bit can only be shown by the bench's scenarios. The same holds for the truncation of fetched words, and for requests thrown at a busy fetch that must leave its outcome untouched.

// File: rtl/xsa_pkg.sv
package xsa_pkg;
  localparam int XS_WORD_W  = 32;
  localparam int XS_ADDR_W  = 20;
  localparam int XS_SHORT_W = 17;

  typedef enum logic [1:0] {
    CTX_PROG  = 2'b00,
    CTX_INTR  = 2'b01,
    CTX_TRAP  = 2'b10,
    CTX_TRAPX = 2'b11
  } ctx_e;

  typedef enum logic [0:0] {
    SQ_IDLE  = 1'b0,
    SQ_FETCH = 1'b1
  } seq_e;
endpackage

// File: rtl/xsa_rules.sv
module xsa_rules
  import xsa_pkg::*;
(
  input  logic       at,
  input  logic [1:0] ctx,
  input  logic       mode_ma,
  input  logic       mode_mm,
  input  logic       stat_map,
  output logic       short_sel,
  output logic       idx_ok,
  output logic       mapped
);
  logic ext_mode;

  always_comb begin
    // program context always obeys AT directly; entries only in extended mode
    ext_mode  = (ctx == CTX_PROG) || (mode_ma && !mode_mm);
    short_sel = ext_mode && at;
    idx_ok    = at;
    mapped    = at && stat_map;
  end
endmodule

// File: rtl/xsa_seq.sv
module xsa_seq
  import xsa_pkg::*;
#(
  parameter int WORD_W  = XS_WORD_W,
  parameter int ADDR_W  = XS_ADDR_W,
  parameter int SHORT_W = XS_SHORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              indirect,
  input  logic [ADDR_W-1:0] field,
  input  logic              short_in,
  input  logic              idx_in,
  input  logic              map_in,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] addr_out,
  output logic              short_sel,
  output logic              idx_ok,
  output logic              mapped
);
  localparam logic [ADDR_W-1:0] SHORT_MASK =
    {{(ADDR_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  seq_e              st_q, st_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              short_q, short_d, idx_q, idx_d, map_q, map_d;
  logic              req_q, req_d;
  logic [ADDR_W-1:0] maddr_q, maddr_d;
  logic              flag_en;
  logic [ADDR_W-1:0] direct_addr;
  logic [ADDR_W-1:0] fetched_addr;

  always_comb begin
    direct_addr  = short_in ? (field & SHORT_MASK) : field;
    fetched_addr = short_q ? (mem_rdata[ADDR_W-1:0] & SHORT_MASK)
                           : mem_rdata[ADDR_W-1:0];
    st_d    = st_q;
    done_d  = 1'b0;
    addr_d  = addr_q;
    req_d   = req_q;
    maddr_d = maddr_q;
    flag_en = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          flag_en = 1'b1;
          if (indirect) begin
            st_d    = SQ_FETCH;
            req_d   = 1'b1;
            maddr_d = direct_addr;
          end else begin
            done_d = 1'b1;
            addr_d = direct_addr;
          end
        end
      end
      SQ_FETCH: begin
        if (mem_ack) begin
          st_d   = SQ_IDLE;
          req_d  = 1'b0;
          done_d = 1'b1;
          addr_d = fetched_addr;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
    short_d = flag_en ? short_in : short_q;
    idx_d   = flag_en ? idx_in   : idx_q;
    map_d   = flag_en ? map_in   : map_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      done_q  <= 1'b0;
      addr_q  <= '0;
      short_q <= 1'b0;
      idx_q   <= 1'b0;
      map_q   <= 1'b0;
      req_q   <= 1'b0;
      maddr_q <= '0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      addr_q  <= addr_d;
      short_q <= short_d;
      idx_q   <= idx_d;
      map_q   <= map_d;
      req_q   <= req_d;
      maddr_q <= maddr_d;
    end
  end

  assign mem_req   = req_q;
  assign mem_addr  = maddr_q;
  assign done      = done_q;
  assign addr_out  = addr_q;
  assign short_sel = short_q;
  assign idx_ok    = idx_q;
  assign mapped    = map_q;

  // R7: an unanswered read keeps asking at the same address
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R8: an acknowledge completes the request on the next cycle
  assert_ack_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (done && !mem_req));
  // R9: no completion while a fetch is still waiting
  assert_no_early_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> !done);
  // R3: a short result carries nothing above the short field
  assert_short_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && short_sel) |-> (addr_out[ADDR_W-1:SHORT_W] == '0));
endmodule

// File: rtl/xstat_addr_sel.sv
module xstat_addr_sel
  import xsa_pkg::*;
#(
  parameter int WORD_W  = XS_WORD_W,
  parameter int ADDR_W  = XS_ADDR_W,
  parameter int SHORT_W = XS_SHORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [1:0]        ctx,
  input  logic              mode_ma,
  input  logic              mode_mm,
  input  logic              stat_map,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] addr_out,
  output logic              short_sel,
  output logic              idx_ok,
  output logic              ind_ok,
  output logic              mapped
);
  // big-endian bit n of the word sits at vector index WORD_W-1-n (R1)
  localparam int IND_POS = WORD_W - 1;
  localparam int AT_POS  = WORD_W - 1 - 10;

  logic at_bit, ind_bit;
  logic r_short, r_idx, r_map;

  assign at_bit  = instr[AT_POS];
  assign ind_bit = instr[IND_POS];
  assign ind_ok  = 1'b1;

  xsa_rules u_rules (
    .at        (at_bit),
    .ctx       (ctx),
    .mode_ma   (mode_ma),
    .mode_mm   (mode_mm),
    .stat_map  (stat_map),
    .short_sel (r_short),
    .idx_ok    (r_idx),
    .mapped    (r_map)
  );

  xsa_seq #(
    .WORD_W  (WORD_W),
    .ADDR_W  (ADDR_W),
    .SHORT_W (SHORT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (req_valid),
    .indirect  (ind_bit),
    .field     (instr[ADDR_W-1:0]),
    .short_in  (r_short),
    .idx_in    (r_idx),
    .map_in    (r_map),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done      (done),
    .addr_out  (addr_out),
    .short_sel (short_sel),
    .idx_ok    (idx_ok),
    .mapped    (mapped)
  );

  // R2: a direct AT=0 request from idle ends unindexed and real
  assert_at0_real_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mem_req && !ind_bit && !at_bit) |=> (done && !idx_ok && !mapped));
endmodule

// File: tb/test_xstat_addr_sel.sv
module test_xstat_addr_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0]  ctx = '0;
  logic        mode_ma = 1'b0, mode_mm = 1'b0, stat_map = 1'b0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_req, done, short_sel, idx_ok, ind_ok, mapped;
  logic [19:0] mem_addr, addr_out;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xstat_addr_sel i_xstat_addr_sel (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr), .ctx(ctx),
    .mode_ma(mode_ma), .mode_mm(mode_mm), .stat_map(stat_map),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .addr_out(addr_out), .short_sel(short_sel), .idx_ok(idx_ok),
    .ind_ok(ind_ok), .mapped(mapped)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {short, idx, map, addr[19:0]}
  function automatic logic [22:0] model(input logic [31:0] ins, input logic [1:0] c,
                                        input logic ma, input logic mm, input logic sm,
                                        input logic [31:0] word);
    logic at, ext, sh;
    logic [19:0] a;
    at  = ins[21];
    ext = (c == 2'b00) || (ma && !mm);
    sh  = ext && at;
    a   = sh ? {3'b000, word[16:0]} : word[19:0];
    return {sh, at, at && sm, a};
  endfunction

  function automatic string rule_tag(input logic [31:0] ins, input logic [1:0] c,
                                     input logic ma, input logic mm);
    if (c == 2'b00) return ins[21] ? "R3" : "R2";
    if (ma && !mm) return "R4";
    return "R5";
  endfunction

  task automatic run(input logic [31:0] ins, input logic [1:0] c, input logic ma,
                     input logic mm, input logic sm, input logic [31:0] rd,
                     input int dly, input bit interfere);
    logic [22:0] e_dir, e_fin;
    string t;
    t = rule_tag(ins, c, ma, mm);
    e_dir = model(ins, c, ma, mm, sm, ins);
    @(negedge clk);
    instr = ins; ctx = c; mode_ma = ma; mode_mm = mm; stat_map = sm; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (ins[31]) begin
      chk(mem_req == 1'b1, "R7 mem_req", {31'b0, mem_req}, 32'd1);
      chk(mem_addr == e_dir[19:0], "R7 mem_addr", {12'b0, mem_addr}, {12'b0, e_dir[19:0]});
      chk(done == 1'b0, "R8 no done before ack", {31'b0, done}, 32'd0);
      for (int k = 0; k < dly; k++) begin
        if (interfere) begin
          instr = $urandom; ctx = 2'($urandom); stat_map = ~sm; req_valid = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b0 && mem_req == 1'b1 && mem_addr == e_dir[19:0],
            "R9 busy ignores request", {11'b0, done, mem_addr}, {11'b0, 1'b0, e_dir[19:0]});
      end
      mem_ack = 1'b1; mem_rdata = rd;
      @(negedge clk);
      mem_ack = 1'b0; mem_rdata = $urandom;
      e_fin = model(ins, c, ma, mm, sm, rd);
      chk(done == 1'b1 && mem_req == 1'b0, "R8 done after ack", {30'b0, done, mem_req}, 32'd2);
      chk({short_sel, idx_ok, mapped, addr_out} == e_fin, {"R7 fetched result ", t},
          {9'b0, short_sel, idx_ok, mapped, addr_out}, {9'b0, e_fin});
    end else begin
      chk(done == 1'b1 && mem_req == 1'b0, "R8 direct done", {30'b0, done, mem_req}, 32'd2);
      chk({short_sel, idx_ok, mapped, addr_out} == e_dir, {"R1 field select ", t},
          {9'b0, short_sel, idx_ok, mapped, addr_out}, {9'b0, e_dir});
    end
    chk(ind_ok == 1'b1, "R6 ind_ok", {31'b0, ind_ok}, 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    chk(done == 0 && mem_req == 0 && addr_out == 0 && idx_ok == 0 && mapped == 0 && short_sel == 0,
        "R10 reset state", {10'b0, done, mem_req, addr_out}, 32'd0);
    rst_n = 1'b1;
    // directed: AT position and field widths
    run(32'h0000_0000 | 32'h000F_FFFF, 2'b00, 0, 0, 1, 0, 0, 0);            // R2
    run(32'h0020_0000 | 32'h000F_FFFF, 2'b00, 0, 0, 1, 0, 0, 0);            // R3 short, mapped
    run(32'h0020_0000 | 32'h0009_5555, 2'b00, 0, 0, 0, 0, 0, 0);            // R3 real
    run(32'h0020_0000 | 32'h000A_AAAA, 2'b01, 1, 0, 1, 0, 0, 0);            // R4 interrupt
    run(32'h0000_0000 | 32'h000A_AAAA, 2'b10, 1, 0, 1, 0, 0, 0);            // R4 trap AT=0
    run(32'h0020_0000 | 32'h000F_0F0F, 2'b10, 1, 1, 1, 0, 0, 0);            // R5 AT=1 long mapped
    run(32'h0000_0000 | 32'h000F_0F0F, 2'b11, 0, 0, 1, 0, 0, 0);            // R5 AT=0
    run(32'h0040_0000 | 32'h000E_0001, 2'b01, 0, 1, 1, 0, 0, 0);            // R1 AI bit does not act as AT
    // directed indirect
    run(32'h8020_0000 | 32'h0001_2345, 2'b00, 0, 0, 1, 32'hFFFF_FFFF, 0, 0); // R7 short truncation
    run(32'h8020_0000 | 32'h0001_2345, 2'b01, 0, 0, 1, 32'hFFFF_FFFF, 3, 1); // R7/R9 long, busy
    run(32'h8000_0000 | 32'h0005_4321, 2'b10, 1, 0, 0, 32'h1234_5678, 5, 1); // R9
    for (int i = 0; i < 400; i++) begin
      run($urandom, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          $urandom, int'($urandom % 4), 1'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule